// File: doc/BRIEF.md
# Card Controller Register Front End with Sticky Status and Two Interrupt Lines

This block is the register-facing side of a memory-card host controller. A simple word-addressed bus, with a write strobe, a read strobe and a 12-bit byte address, reaches a set of configuration registers. These are the supply control, clock divider, command argument, command word, data timeout, transfer length and data control registers. Each one drives an output that feeds the command and data engines.

The engines report back in two ways:
- **Event pulses** set bits in an 11-bit sticky event field. The host clears those bits by writing ones to a dedicated clear address.
- **FIFO level flags** are 11 bits that are shown live in the upper part of the 22-bit status word. The clear address cannot change them.

Two independent 22-bit mask registers select which status bits drive each of two level interrupt lines.

The engines also own the response words, the remaining byte count and the FIFO data. The block simply presents these on reads. It turns any access in the FIFO window into a one-cycle push or pop strobe. Eight fixed identification bytes sit at the top of the 4 KB space.

Read data is combinational from the address. Register writes take effect at the next rising clock edge.

Top module: `mmc_regfront`

## Requirements
- R1: After reset every configuration register, both masks and the sticky event field read as zero, and with the FIFO flags low both interrupt lines are low.
- R2: Supply (0x00), clock divider (0x04) and data control (0x2C) keep only the low 8 bits of a write. Transfer length (0x28) keeps the low 16 bits. Argument (0x08), command (0x0C) and data timeout (0x24) keep all 32 bits. Each reads back zero-extended at its offset and appears on its output port.
- R3: Status at 0x34 reads {10'b0, fifo_flags[10:0], events[10:0]}. A pulse on evt_set[i] sets event bit i from the next cycle, and the bit stays set until cleared.
- R4: A write to 0x38 clears event bits where wdata[10:0] is 1. Bits 31:11 of that write have no effect, and the FIFO flags in status remain live.
- R5: When evt_set[i] and a clear of bit i occur in the same cycle, bit i ends up set.
- R6: irq_a is high exactly when (status & mask_a) is nonzero. irq_b is high exactly when (status & mask_b) is nonzero.
- R7: Masks at 0x3C (irq_a) and 0x40 (irq_b) keep the low 22 bits and read back zero-extended.
- R8: Reads of 0x14, 0x18, 0x1C and 0x20 return resp_in words 0 to 3, with word k = resp_in[32k+31:32k]. Reads of 0x30 return dcount_in. Reads of 0x48 return (dcount_in+3)>>2.
- R9: Any access at 0x80 to 0xBC reads fifo_rdata. A read there raises fifo_pop and a write there raises fifo_push, each for that cycle only. No access outside that window raises either strobe.
- R10: Reads at 0xFE0, 0xFE4, … , 0xFFC return the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, one per word.
- R11: Reads of unmapped offsets return zero. Writes to unmapped or read-only offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_set | input | 11 | Event set pulses from the engines |
| fifo_flags | input | 11 | Live FIFO level flags |
| resp_in | input | 128 | Four response words |
| dcount_in | input | 16 | Remaining byte count |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_push | output | 1 | Write into the FIFO window this cycle |
| fifo_pop | output | 1 | Read from the FIFO window this cycle |
| power_q | output | 8 | Supply control |
| clkdiv_q | output | 8 | Clock divider |
| arg_q | output | 32 | Command argument |
| cmd_q | output | 32 | Command word |
| dtimer_q | output | 32 | Data timeout |
| dlen_q | output | 16 | Transfer length |
| dctrl_q | output | 8 | Data control |
| irq_a | output | 1 | First masked interrupt |
| irq_b | output | 1 | Second masked interrupt |

## Verification
The assertions assume that a single cycle never carries both a read and a write. The FIFO-strobe exclusivity check depends on this. The stimulus issues each access from its own task, which raises exactly one strobe. Set pulses and FIFO flags are changed only between clock edges.

The collision case, a set pulse and a clear of the same bit, is driven on purpose. This confirms that the set-wins rule holds on the bus-visible status.

// File: rtl/mmc_regfront.sv
module mmc_regfront #(
  parameter int AW = 12,
  parameter int EW = 11,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [EW-1:0] evt_set,
  input  logic [LW-1:0] fifo_flags,
  input  logic [127:0]  resp_in,
  input  logic [15:0]   dcount_in,
  input  logic [31:0]   fifo_rdata,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic [7:0]    power_q,
  output logic [7:0]    clkdiv_q,
  output logic [31:0]   arg_q,
  output logic [31:0]   cmd_q,
  output logic [31:0]   dtimer_q,
  output logic [15:0]   dlen_q,
  output logic [7:0]    dctrl_q,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int SW = EW + LW;
  localparam int WA = AW - 2;

  logic [WA-1:0] wa;
  logic [EW-1:0] events, clr_bits;
  logic [SW-1:0] status, mask_a, mask_b;
  logic          in_fifo, in_id, clr_hit;
  logic [16:0]   words_left;
  logic [7:0]    id_byte;

  assign wa        = bus_addr[AW-1:2];
  assign in_fifo   = (wa >= WA'(32)) && (wa <= WA'(47));
  assign in_id     = (wa >= WA'(1016));
  assign clr_hit   = bus_wr && (wa == WA'(14));
  assign clr_bits  = clr_hit ? bus_wdata[EW-1:0] : '0;
  assign status    = {fifo_flags, events};
  assign irq_a     = |(status & mask_a);
  assign irq_b     = |(status & mask_b);
  assign fifo_push = bus_wr && in_fifo;
  assign fifo_pop  = bus_rd && in_fifo;
  assign words_left = ({1'b0, dcount_in} + 17'd3) >> 2;

  always_comb begin
    case (wa[2:0])
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      power_q  <= '0;
      clkdiv_q <= '0;
      arg_q    <= '0;
      cmd_q    <= '0;
      dtimer_q <= '0;
      dlen_q   <= '0;
      dctrl_q  <= '0;
      mask_a   <= '0;
      mask_b   <= '0;
      events   <= '0;
    end else begin
      events <= (events & ~clr_bits) | evt_set;
      if (bus_wr) begin
        case (wa)
          WA'(0):  power_q  <= bus_wdata[7:0];
          WA'(1):  clkdiv_q <= bus_wdata[7:0];
          WA'(2):  arg_q    <= bus_wdata;
          WA'(3):  cmd_q    <= bus_wdata;
          WA'(9):  dtimer_q <= bus_wdata;
          WA'(10): dlen_q   <= bus_wdata[15:0];
          WA'(11): dctrl_q  <= bus_wdata[7:0];
          WA'(15): mask_a   <= bus_wdata[SW-1:0];
          WA'(16): mask_b   <= bus_wdata[SW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_fifo) bus_rdata = fifo_rdata;
    else if (in_id) bus_rdata = {24'd0, id_byte};
    else begin
      case (wa)
        WA'(0):  bus_rdata = {24'd0, power_q};
        WA'(1):  bus_rdata = {24'd0, clkdiv_q};
        WA'(2):  bus_rdata = arg_q;
        WA'(3):  bus_rdata = cmd_q;
        WA'(5):  bus_rdata = resp_in[31:0];
        WA'(6):  bus_rdata = resp_in[63:32];
        WA'(7):  bus_rdata = resp_in[95:64];
        WA'(8):  bus_rdata = resp_in[127:96];
        WA'(9):  bus_rdata = dtimer_q;
        WA'(10): bus_rdata = {16'd0, dlen_q};
        WA'(11): bus_rdata = {24'd0, dctrl_q};
        WA'(12): bus_rdata = {16'd0, dcount_in};
        WA'(13): bus_rdata = 32'(status);
        WA'(15): bus_rdata = 32'(mask_a);
        WA'(16): bus_rdata = 32'(mask_b);
        WA'(18): bus_rdata = 32'(words_left);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((events & $past(evt_set)) == $past(evt_set)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((events & $past(bus_wdata[EW-1:0] & ~evt_set)) == '0));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((events & $past(events)) == $past(events)));

  // R6
  irq_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == '0) |-> !irq_a);

  // R6
  irq_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_b == '0) |-> !irq_b);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_pop));

  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (wa == WA'(12))) |=> ($stable(arg_q) && $stable(mask_a) && $stable(dlen_q)));
endmodule

// File: tb/tb_mmc_regfront.sv
module tb_mmc_regfront;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [10:0] evt_set = '0, fifo_flags = '0;
  logic [127:0] resp_in = '0;
  logic [15:0] dcount_in = '0;
  logic [31:0] fifo_rdata = '0;
  logic fifo_push, fifo_pop, irq_a, irq_b;
  logic [7:0] power_q, clkdiv_q, dctrl_q;
  logic [31:0] arg_q, cmd_q, dtimer_q;
  logic [15:0] dlen_q;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0]  m_pwr, m_clk, m_ctl;
  logic [31:0] m_arg, m_cmd, m_tmr;
  logic [15:0] m_len;
  logic [10:0] m_evt;
  logic [21:0] m_ma, m_mb;
  byte unsigned idtab [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  mmc_regfront dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    int off = int'({a[11:2], 2'b00});
    if (off >= 'h80 && off <= 'hBC) return fifo_rdata;
    if (off >= 'hFE0) return {24'd0, idtab[(off - 'hFE0) / 4]};
    case (off)
      'h00: return m_pwr;
      'h04: return m_clk;
      'h08: return m_arg;
      'h0C: return m_cmd;
      'h14: return resp_in[31:0];
      'h18: return resp_in[63:32];
      'h1C: return resp_in[95:64];
      'h20: return resp_in[127:96];
      'h24: return m_tmr;
      'h28: return m_len;
      'h2C: return m_ctl;
      'h30: return dcount_in;
      'h34: return {10'd0, fifo_flags, m_evt};
      'h3C: return m_ma;
      'h40: return m_mb;
      'h48: return (int'(dcount_in) + 3) / 4;
      default: return 0;
    endcase
  endfunction

  task automatic model_update();
    int off = int'({bus_addr[11:2], 2'b00});
    if (!rst_n) begin
      m_pwr = 0; m_clk = 0; m_ctl = 0; m_arg = 0; m_cmd = 0; m_tmr = 0;
      m_len = 0; m_evt = 0; m_ma = 0; m_mb = 0;
      return;
    end
    if (bus_wr && off == 'h38) m_evt = m_evt & ~bus_wdata[10:0];
    m_evt = m_evt | evt_set;
    if (bus_wr) case (off)
      'h00: m_pwr = bus_wdata[7:0];
      'h04: m_clk = bus_wdata[7:0];
      'h08: m_arg = bus_wdata;
      'h0C: m_cmd = bus_wdata;
      'h24: m_tmr = bus_wdata;
      'h28: m_len = bus_wdata[15:0];
      'h2C: m_ctl = bus_wdata[7:0];
      'h3C: m_ma = bus_wdata[21:0];
      'h40: m_mb = bus_wdata[21:0];
      default: ;
    endcase
  endtask

  task automatic tick();
    int off;
    logic [21:0] st;
    #1;
    off = int'({bus_addr[11:2], 2'b00});
    st = {fifo_flags, m_evt};
    if (rst_n) begin
      if (bus_rd) chk(tag, "rdata", bus_rdata, exp_rd(bus_addr));
      chk("R6", "irq_a", {31'd0, irq_a}, {31'd0, |(st & m_ma)});
      chk("R6", "irq_b", {31'd0, irq_b}, {31'd0, |(st & m_mb)});
      chk("R9", "fifo_push", {31'd0, fifo_push}, {31'd0, bus_wr && off >= 'h80 && off <= 'hBC});
      chk("R9", "fifo_pop", {31'd0, fifo_pop}, {31'd0, bus_rd && off >= 'h80 && off <= 'hBC});
      chk("R2", "outputs", {power_q, clkdiv_q, dctrl_q, 8'd0}, {m_pwr, m_clk, m_ctl, 8'd0});
      chk("R2", "wide outputs", arg_q ^ cmd_q ^ dtimer_q ^ {16'd0, dlen_q},
          m_arg ^ m_cmd ^ m_tmr ^ {16'd0, m_len});
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    tick();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(int a, string t);
    tag = t; bus_rd = 1; bus_addr = 12'(a);
    tick();
    bus_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a <= 'h48; a += 4) rd(a, "R1");
    chk("R1", "irq pair", {30'd0, irq_a, irq_b}, 0);
    // R2 width of configuration registers
    wr('h00, 32'hA5A5_12F3); wr('h04, 32'h0000_FF7E); wr('h08, 32'hDEAD_BEEF);
    wr('h0C, 32'h0000_0452); wr('h24, 32'h1234_5678); wr('h28, 32'hCAFE_8001);
    wr('h2C, 32'hFFFF_FF0B);
    foreach (idtab[i]) rd(i * 4, "R2");
    rd('h24, "R2"); rd('h28, "R2"); rd('h2C, "R2");
    // R7 masks
    wr('h3C, 32'hFFFF_FFFF); rd('h3C, "R7");
    wr('h40, 32'hFFC0_0000); rd('h40, "R7");
    wr('h3C, 32'h0000_0008); wr('h40, 32'h0000_8000);
    // R3 sticky events and live flags
    evt_set = 11'h001; tick(); evt_set = 0;
    rd('h34, "R3");
    evt_set = 11'h408; tick(); evt_set = 0;
    repeat (3) rd('h34, "R3");
    fifo_flags = 11'h010; rd('h34, "R3");
    fifo_flags = 11'h7FF; rd('h34, "R3");
    // R4 clear only low field
    wr('h38, 32'hFFFF_F800); rd('h34, "R4");
    wr('h38, 32'h0000_0008); rd('h34, "R4");
    fifo_flags = 11'h000; rd('h34, "R4");
    // R5 collision
    evt_set = 11'h004; wr('h38, 32'h0000_07FF); evt_set = 0;
    rd('h34, "R5");
    evt_set = 11'h008; wr('h38, 32'h0000_0008); evt_set = 0;
    rd('h34, "R5");
    // R6 masked interrupts
    wr('h38, 32'h7FF); rd('h34, "R6");
    fifo_flags = 11'h010; tick(); fifo_flags = 0; tick();
    wr('h3C, 32'h0030_0000); fifo_flags = 11'h400; tick(); fifo_flags = 0;
    // R8 engine values
    resp_in = {32'h0BAD_F00D, 32'h1357_9BDF, 32'h0246_8ACE, 32'hFEED_FACE};
    for (int a = 'h14; a <= 'h20; a += 4) rd(a, "R8");
    foreach (idtab[i]) begin
      dcount_in = (i < 4) ? 16'(i) : (i == 7 ? 16'hFFFF : 16'(i * 13));
      rd('h30, "R8"); rd('h48, "R8");
    end
    // R9 FIFO window
    fifo_rdata = 32'h5555_AAAA;
    rd('h80, "R9"); rd('hBC, "R9"); rd('h7C, "R9"); rd('hC0, "R9");
    wr('h80, 32'h1); wr('hA4, 32'h2); wr('hC0, 32'h3); wr('h7C, 32'h4);
    // R10 identification bytes
    for (int a = 'hFE0; a <= 'hFFC; a += 4) rd(a, "R10");
    // R11 unmapped and read-only
    foreach (idtab[i]) begin
      int ua [8] = '{'h44, 'h100, 'h30, 'h14, 'h34, 'h48, 'h10, 'hFE0};
      wr(ua[i], 32'hFFFF_FFFF);
    end
    for (int a = 0; a <= 'h48; a += 4) rd(a, "R11");
    rd('h44, "R11"); rd('h10, "R11"); rd('h200, "R11"); rd('hFDC, "R11");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule